// File: doc/BRIEF.md
# Game Controller Serial Reader

This block gives a processor byte-wide register access to two game pads, each with eight buttons. The pads' parallel button lines and their connect lines enter as block inputs. Software captures a snapshot of both pads through a shared strobe register at the first port address. It then reads the pads one button at a time. The first pad answers at the base address and the second at the address one above it. Each read yields one button in bit 0 of the returned byte. The other bits of that byte carry the pad's connect status and a fixed pattern.

The strobe is a two-state machine. From `STB_LOW`, a write with bit 0 set to the base address moves it to `STB_HIGH` (transition *arm*). From `STB_HIGH`, a write with bit 0 clear moves it back to `STB_LOW` (transition *release*). The release issues a one-cycle load pulse. Each pad has its own three-state machine. `PAD_DRAINED` is entered at reset and after the last button has been read out. `PAD_HOLD` applies while the strobe is high. `PAD_SHIFT` applies while latched buttons remain. A pad leaves `PAD_DRAINED` for `PAD_HOLD` when the strobe is seen high (*hold*). It goes to `PAD_SHIFT` on the load pulse from any state (*load*). It stays in `PAD_SHIFT` on a read of its own port (*advance*). The read of its last button returns it to `PAD_DRAINED` (*empty*). From `PAD_SHIFT` it returns to `PAD_HOLD` if the strobe is armed again. Read data is registered and appears with `rd_valid` on the cycle after the read request.

Top module: `joy_serial_reader`

## Requirements
- R1: After reset `rd_valid` is 0, and until the first strobe every read of either pad returns 1 in bit 0.
- R2: A write with bit 0 = 1 followed by a write with bit 0 = 0, both to the base address, captures the buttons of both pads at the second write and restarts both pads at their first button.
- R3: Successive reads of a pad return its buttons in the order A, B, SELECT, START, UP, DOWN, LEFT, RIGHT. The pad's input vector carries A in bit 0 through RIGHT in bit 7, and 1 means pressed.
- R4: Every returned byte has bit 7 = 0, bit 6 = 1 and bits 5..2 = 0. Bit 1 is 0 when the pad's connect input is 1 and is 1 otherwise. A pressed button on a connected pad therefore reads 0x41.
- R5: While the strobe holds 1, a read returns the live state of that pad's button A and does not move the pad to its next button.
- R6: Once all eight buttons of a pad have been read, further reads of it return 1 in bit 0 until the next strobe release.
- R7: Each pad keeps its own position, which moves only on a read of that pad's address.
- R8: The second pad is read at base address + 1. Writes there do not change the strobe. Reads at any address other than the two pad addresses produce no `rd_valid`.
- R9: Read data and `rd_valid` appear on the clock cycle after the read request.
- R10: Button changes after the capture do not alter the values being read out.
- R11: A write with bit 0 = 0 while the strobe is already low does not recapture buttons or restart either pad.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Access address |
| bus_wr | input | 1 | Write request |
| bus_rd | input | 1 | Read request |
| bus_wdata | input | 8 | Write data; only bit 0 is used |
| pad_buttons | input | NUM_PADS*NUM_BTN | Parallel buttons, pad p at bits p*NUM_BTN upward |
| pad_present | input | NUM_PADS | 1 when pad p is connected |
| rd_data | output | 8 | Returned byte |
| rd_valid | output | 1 | rd_data holds the answer to the previous cycle's read |

## Verification
The hardest cases to observe from the ports are the ignored writes: a write with bit 0 clear while the strobe is low, and strobe writes to the second pad address. A wrong design would show no change unless the recaptured value differed from the one already latched. The stimulus changes every button input after the capture. It then issues those writes partway through one pad's readout, after the other pad has drained. A false recapture then shows up as a 0 where a 1 is expected on both pads. Interleaved reads of the two pads confirm that their positions are independent.

// File: rtl/joy_pkg.sv
package joy_pkg;

    typedef enum logic {
        STB_LOW,
        STB_HIGH
    } stb_state_t;

    typedef enum logic [1:0] {
        PAD_DRAINED,
        PAD_HOLD,
        PAD_SHIFT
    } pad_state_t;

    localparam logic [5:0] FIXED_HIGH_BITS = 6'b010000;

endpackage

// File: rtl/joy_strobe_ctl.sv
module joy_strobe_ctl
    import joy_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_hit,
    input  logic wr_bit,
    output logic strobe_on,
    output logic load_pulse
);

    stb_state_t state_q;
    stb_state_t state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= STB_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d    = state_q;
        load_pulse = 1'b0;
        unique case (state_q)
            STB_LOW: begin
                if (wr_hit && wr_bit) begin
                    state_d = STB_HIGH;
                end
            end
            STB_HIGH: begin
                if (wr_hit && !wr_bit) begin
                    state_d    = STB_LOW;
                    load_pulse = 1'b1;
                end
            end
            default: state_d = STB_LOW;
        endcase
    end

    assign strobe_on = (state_q == STB_HIGH);

endmodule

// File: rtl/joy_pad_shifter.sv
module joy_pad_shifter
    import joy_pkg::*;
#(
    parameter int NUM_BTN = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               strobe_on,
    input  logic               load_pulse,
    input  logic               rd_hit,
    input  logic [NUM_BTN-1:0] buttons,
    output logic               serial_bit
);

    localparam int IDX_W = (NUM_BTN > 1) ? $clog2(NUM_BTN) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BTN - 1);

    pad_state_t         state_q, state_d;
    logic [NUM_BTN-1:0] shreg_q, shreg_d;
    logic [IDX_W-1:0]   idx_q, idx_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PAD_DRAINED;
            shreg_q <= '1;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            shreg_q <= shreg_d;
            idx_q   <= idx_d;
        end
    end

    always_comb begin
        state_d = state_q;
        shreg_d = shreg_q;
        idx_d   = idx_q;
        unique case (state_q)
            PAD_DRAINED: begin
                if (load_pulse) begin
                    state_d = PAD_SHIFT;
                    shreg_d = buttons;
                    idx_d   = '0;
                end else if (strobe_on) begin
                    state_d = PAD_HOLD;
                end
            end
            PAD_HOLD: begin
                if (load_pulse) begin
                    state_d = PAD_SHIFT;
                    shreg_d = buttons;
                    idx_d   = '0;
                end
            end
            PAD_SHIFT: begin
                if (load_pulse) begin
                    shreg_d = buttons;
                    idx_d   = '0;
                end else if (strobe_on) begin
                    state_d = PAD_HOLD;
                end else if (rd_hit) begin
                    shreg_d = {1'b1, shreg_q[NUM_BTN-1:1]};
                    idx_d   = idx_q + 1'b1;
                    if (idx_q == LAST_IDX) begin
                        state_d = PAD_DRAINED;
                        idx_d   = '0;
                    end
                end
            end
            default: state_d = PAD_DRAINED;
        endcase
    end

    always_comb begin
        if (strobe_on) begin
            serial_bit = buttons[0];
        end else if (state_q == PAD_SHIFT) begin
            serial_bit = shreg_q[0];
        end else begin
            serial_bit = 1'b1;
        end
    end

endmodule

// File: rtl/joy_read_port.sv
module joy_read_port
    import joy_pkg::*;
#(
    parameter int NUM_PADS = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rd_fire,
    input  logic [NUM_PADS-1:0] sel_onehot,
    input  logic [NUM_PADS-1:0] serial_bits,
    input  logic [NUM_PADS-1:0] present,
    output logic [7:0]          rd_data,
    output logic                rd_valid
);

    logic bit0_sel;
    logic absent_sel;

    always_comb begin
        bit0_sel   = 1'b0;
        absent_sel = 1'b0;
        for (int p = 0; p < NUM_PADS; p++) begin
            if (sel_onehot[p]) begin
                bit0_sel   = serial_bits[p];
                absent_sel = ~present[p];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_fire;
            if (rd_fire) begin
                rd_data <= {FIXED_HIGH_BITS, absent_sel, bit0_sel};
            end
        end
    end

endmodule

// File: rtl/joy_serial_reader.sv
module joy_serial_reader
    import joy_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h4016,
    parameter int                NUM_PADS  = 2,
    parameter int                NUM_BTN   = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic                         bus_wr,
    input  logic                         bus_rd,
    input  logic [7:0]                   bus_wdata,
    input  logic [NUM_PADS*NUM_BTN-1:0]  pad_buttons,
    input  logic [NUM_PADS-1:0]          pad_present,
    output logic [7:0]                   rd_data,
    output logic                         rd_valid
);

    localparam logic [ADDR_W-1:0] PAD_SPAN = ADDR_W'(NUM_PADS);

    logic [ADDR_W-1:0]   offset;
    logic                addr_hit;
    logic [NUM_PADS-1:0] sel_onehot;
    logic [NUM_PADS-1:0] serial_bits;
    logic                strobe_on;
    logic                load_pulse;
    logic                rd_fire;

    assign offset   = bus_addr - BASE_ADDR;
    assign addr_hit = (offset < PAD_SPAN);
    assign rd_fire  = bus_rd && addr_hit;

    joy_strobe_ctl u_strobe (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_hit     (bus_wr && (offset == '0)),
        .wr_bit     (bus_wdata[0]),
        .strobe_on  (strobe_on),
        .load_pulse (load_pulse)
    );

    for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
        assign sel_onehot[p] = addr_hit && (offset == ADDR_W'(p));

        joy_pad_shifter #(.NUM_BTN(NUM_BTN)) u_shift (
            .clk        (clk),
            .rst_n      (rst_n),
            .strobe_on  (strobe_on),
            .load_pulse (load_pulse),
            .rd_hit     (bus_rd && sel_onehot[p]),
            .buttons    (pad_buttons[p*NUM_BTN +: NUM_BTN]),
            .serial_bit (serial_bits[p])
        );
    end

    joy_read_port #(.NUM_PADS(NUM_PADS)) u_read (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_fire     (rd_fire),
        .sel_onehot  (sel_onehot),
        .serial_bits (serial_bits),
        .present     (pad_present),
        .rd_data     (rd_data),
        .rd_valid    (rd_valid)
    );

endmodule

// File: rtl/joy_serial_reader_chk.sv
module joy_serial_reader_chk #(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h4016,
    parameter int                NUM_PADS  = 2,
    parameter int                NUM_BTN   = 8
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [ADDR_W-1:0]           bus_addr,
    input logic                        bus_wr,
    input logic                        bus_rd,
    input logic [NUM_PADS*NUM_BTN-1:0] pad_buttons,
    input logic [NUM_PADS-1:0]         pad_present,
    input logic [7:0]                  rd_data,
    input logic                        rd_valid,
    input logic                        strobe_on,
    input logic                        load_pulse
);

    localparam logic [ADDR_W-1:0] PAD_SPAN = ADDR_W'(NUM_PADS);

    logic [ADDR_W-1:0] ofs_c;
    logic              hit_c;
    logic              exp_absent_q;
    logic              live_a_q;
    logic              strobe_q;

    assign ofs_c = bus_addr - BASE_ADDR;
    assign hit_c = (ofs_c < PAD_SPAN);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exp_absent_q <= 1'b0;
            live_a_q     <= 1'b0;
            strobe_q     <= 1'b0;
        end else begin
            strobe_q <= strobe_on;
            if (bus_rd && hit_c) begin
                exp_absent_q <= 1'b0;
                live_a_q     <= 1'b0;
                for (int p = 0; p < NUM_PADS; p++) begin
                    if (ofs_c == ADDR_W'(p)) begin
                        exp_absent_q <= ~pad_present[p];
                        live_a_q     <= pad_buttons[p*NUM_BTN];
                    end
                end
            end
        end
    end

    // R9
    rd_valid_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid == $past(bus_rd && hit_c && rst_n));

    // R4
    fixed_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> rd_data[7:2] == 6'b010000);

    // R4
    presence_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> rd_data[1] == exp_absent_q);

    // R5
    live_button_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && strobe_q) |-> rd_data[0] == live_a_q);

    // R2
    load_after_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_pulse |-> strobe_on);

    // R2
    load_drops_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_pulse |=> !strobe_on);

    // R8
    second_port_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && ofs_c == ADDR_W'(1)) |=> strobe_on == $past(strobe_on));

endmodule

bind joy_serial_reader joy_serial_reader_chk #(
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (BASE_ADDR),
    .NUM_PADS  (NUM_PADS),
    .NUM_BTN   (NUM_BTN)
) u_chk (.*);

// File: tb/joy_serial_reader_test.sv
module joy_serial_reader_test;

    localparam logic [15:0] BASE = 16'h4016;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [15:0] pad_buttons = '0;
    logic [1:0]  pad_present = '0;
    logic [7:0]  rd_data;
    logic        rd_valid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #5 clk = ~clk;

    joy_serial_reader uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_addr    (bus_addr),
        .bus_wr      (bus_wr),
        .bus_rd      (bus_rd),
        .bus_wdata   (bus_wdata),
        .pad_buttons (pad_buttons),
        .pad_present (pad_present),
        .rd_data     (rd_data),
        .rd_valid    (rd_valid)
    );

    function automatic logic [7:0] eb(input logic b, input logic conn);
        return {1'b0, 1'b1, 4'b0000, ~conn, b};
    endfunction

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input int p, input logic [7:0] exp, input string tag);
        @(negedge clk);
        bus_addr = BASE + 16'(p);
        bus_rd   = 1'b1;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_rd   = 1'b0;
    endtask

    task automatic rd_bad(input logic [15:0] a);
        @(negedge clk);
        bus_addr = a;
        bus_rd   = 1'b1;
        @(negedge clk);
        bus_rd   = 1'b0;
        checks++;
        if (rd_valid !== 1'b0) begin
            errors++;
            $display("FAIL R8: stray read valid got %b expected 0", rd_valid);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R9: unexpected byte got %h expected none", rd_data);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string      t = tag_q.pop_front();
                if (rd_data !== e) begin
                    errors++;
                    $display("FAIL %s: got %h expected %h", t, rd_data, e);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] p0v;
        logic [7:0] p1v;
        repeat (4) @(negedge clk);
        checks++;
        if (rd_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1: rd_valid in reset got %b expected 0", rd_valid);
        end
        rst_n = 1'b1;
        pad_present = 2'b11;
        p0v = 8'hA5;
        p1v = 8'h3C;
        pad_buttons = {p1v, p0v};

        // R1: before any strobe, bit 0 reads 1
        rd(0, eb(1'b1, 1'b1), "R1");
        rd(1, eb(1'b1, 1'b1), "R1");

        // R5: strobe held high gives live A, no advance
        wr(BASE, 8'h01);
        rd(0, eb(1'b1, 1'b1), "R5");
        rd(0, eb(1'b1, 1'b1), "R5");
        pad_buttons[0] = 1'b0;
        rd(0, eb(1'b0, 1'b1), "R5");
        pad_buttons[0] = 1'b1;
        rd(1, eb(1'b0, 1'b1), "R5");

        // R2: release captures; R10: inputs change afterwards
        wr(BASE, 8'h00);
        pad_buttons = '0;

        // R7: interleave the two pads
        for (int i = 0; i < 3; i++) rd(1, eb(p1v[i], 1'b1), "R7");
        // R3: full order on pad 0
        for (int i = 0; i < 8; i++) rd(0, eb(p0v[i], 1'b1), "R3");
        // R6: drained pad reads 1
        rd(0, eb(1'b1, 1'b1), "R6");
        rd(0, eb(1'b1, 1'b1), "R6");

        // R8: strobe writes at second address ignored
        wr(BASE + 16'd1, 8'h01);
        wr(BASE + 16'd1, 8'h00);
        // R11: write 0 while strobe low does not recapture
        wr(BASE, 8'h00);
        rd(0, eb(1'b1, 1'b1), "R11");
        for (int i = 3; i < 8; i++) rd(1, eb(p1v[i], 1'b1), "R11");
        rd(1, eb(1'b1, 1'b1), "R6");

        // R4: disconnected pad 1
        pad_present = 2'b01;
        p0v = 8'h81;
        p1v = 8'hFF;
        pad_buttons = {p1v, p0v};
        wr(BASE, 8'h01);
        wr(BASE + 16'd1, 8'h00);
        rd(0, eb(1'b1, 1'b1), "R8");
        rd(0, eb(1'b1, 1'b1), "R8");
        wr(BASE, 8'h00);
        for (int i = 0; i < 8; i++) rd(1, 8'h43, "R4");
        rd(0, 8'h41, "R4");
        rd(0, eb(p0v[1], 1'b1), "R2");

        rd_bad(BASE + 16'd2);
        rd_bad(BASE - 16'd1);

        repeat (3) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R9: pending bytes got %0d expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule